// File: doc/BRIEF.md
# Line Frame Formatter and Sync Deframer

This block sits between the system side and the line coder of a two-wire digital subscriber link. On the transmit side, it packs two B-channel bytes, two D-channel bits and a housekeeping bit into one line frame every 125 µs. It appends a single sync bit and shifts the frame out one bit per line-bit strobe. Two frame sizes are supported. The high rate (160 kbit/s) uses 20 bits per frame and carries both B bytes, both D bits and the housekeeping bit. The low rate (80 kbit/s) uses 10 bits per frame and carries one B byte and one D bit.

The sync bit toggles from frame to frame. The receive side uses this to find frame alignment in a raw bit stream. It watches one candidate bit position per frame and declares lock only after the position has shown an unbroken alternation for several frames. This guards against payload bits that happen to imitate the pattern. Once lock is declared, the receiver unpacks each frame's fields in one step. If the candidate stops alternating, the receiver drops lock and moves the search forward one bit at a time.

Both directions are paced by clock-enable strobes from an external bit clock recovery or timing stage. Scrambling, line coding and analog functions are handled elsewhere.

Top module: `lfc_line_framer`

## Requirements
- R1: With `rate_hi_i`=1 a frame is 20 bits. The send order is: B1 bits 7 down to 0 at positions 0–7, B2 bits 7 down to 0 at positions 8–15, D bit 0 at position 16, D bit 1 at position 17, housekeeping at position 18 and sync at position 19.
- R2: With `rate_hi_i`=0 a frame is 10 bits. The send order is: B1 bits 7 down to 0 at positions 0–7, D bit 0 at position 8 and sync at position 9. At this rate the second B byte, D bit 1 and housekeeping are neither sent nor recovered; they read as 0 on the receive outputs.
- R3: The transmitted sync bit is 1 in the first frame after reset and inverts in every following frame. `tx_sof_o` is high exactly while position 0 of a frame is on `tx_bit_o`.
- R4: `load_i` copies the parallel inputs into a holding stage. A frame's contents are taken from the holding stage when the frame starts, so a load during a frame affects only the frames after it.
- R5: The receiver asserts `rx_lock_o` on the 8th consecutive candidate sync bit that alternates, and not before.
- R6: While locked, up to 2 consecutive wrong sync bits keep lock; the 3rd consecutive wrong one drops it.
- R7: On a non-alternating candidate during the search, or on loss of lock, the candidate position moves one bit later. The receiver therefore finds a frame boundary at an arbitrary bit offset.
- R8: At the sync bit of each frame for which lock holds after that frame's check, all recovered fields update together and `rx_upd_o` pulses for one clock. At all other times the fields hold their values.
- R9: After reset: `tx_sof_o`=1, `tx_bit_o`=0, `rx_lock_o`=0, `rx_upd_o`=0 and all recovered fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_hi_i | input | 1 | 1: 20-bit frame, 0: 10-bit frame (static) |
| load_i | input | 1 | Capture the parallel transmit fields |
| b1_i | input | B_W | First B-channel byte to send |
| b2_i | input | B_W | Second B-channel byte to send |
| d_i | input | 2 | D-channel bits to send |
| hk_i | input | 1 | Housekeeping bit to send |
| tx_bit_en_i | input | 1 | Transmit line-bit strobe |
| tx_bit_o | output | 1 | Serial line bit |
| tx_sof_o | output | 1 | First bit of a frame is on `tx_bit_o` |
| rx_bit_en_i | input | 1 | Receive line-bit strobe |
| rx_bit_i | input | 1 | Received line bit |
| rx_b1_o | output | B_W | Recovered first B byte |
| rx_b2_o | output | B_W | Recovered second B byte |
| rx_d_o | output | 2 | Recovered D-channel bits |
| rx_hk_o | output | 1 | Recovered housekeeping bit |
| rx_upd_o | output | 1 | Recovered fields updated this cycle |
| rx_lock_o | output | 1 | Frame alignment locked |

## Verification
The bench uses the defaults: 8-bit B channels, an 8-frame lock qualification and a 3-miss loss limit. With these values, the exact frame where lock is declared and the exact miss that drops it both fall within a dozen frames, so the bench checks them one frame at a time. It feeds a stream that starts one bit away from the frame boundary. It chooses payload so that the slid search lands on the true sync after a single slide, which makes the frame of lock predictable. Both frame sizes are covered on transmit and receive, including a load issued in the middle of a frame.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic {ST_HUNT, ST_LOCK} lfc_sync_st_e;

  function automatic int lfc_frame_len(input int bw, input bit hi);
    return hi ? (2 * bw + 4) : (bw + 2);
  endfunction
endpackage

// File: rtl/lfc_tx_hold.sv
module lfc_tx_hold #(
  parameter int B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [B_W-1:0] b1_i,
  input  logic [B_W-1:0] b2_i,
  input  logic [1:0]     d_i,
  input  logic           hk_i,
  output logic [B_W-1:0] b1_o,
  output logic [B_W-1:0] b2_o,
  output logic [1:0]     d_o,
  output logic           hk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_o <= '0;
      b2_o <= '0;
      d_o  <= '0;
      hk_o <= 1'b0;
    end else if (load_i) begin
      b1_o <= b1_i;
      b2_o <= b2_i;
      d_o  <= d_i;
      hk_o <= hk_i;
    end
  end
endmodule

// File: rtl/lfc_tx_ser.sv
module lfc_tx_ser #(
  parameter int B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rate_hi_i,
  input  logic           bit_en_i,
  input  logic [B_W-1:0] b1_i,
  input  logic [B_W-1:0] b2_i,
  input  logic [1:0]     d_i,
  input  logic           hk_i,
  output logic           bit_o,
  output logic           sof_o
);
  localparam int HI_LEN = lfc_pkg::lfc_frame_len(B_W, 1'b1);
  localparam int LO_LEN = lfc_pkg::lfc_frame_len(B_W, 1'b0);
  localparam int PW     = $clog2(HI_LEN);

  logic [PW-1:0]     pos_q, last_pos;
  logic [HI_LEN-1:0] frm_q, frm_d;
  logic              sync_q, at_last;

  assign last_pos = rate_hi_i ? PW'(HI_LEN - 1) : PW'(LO_LEN - 1);
  assign at_last  = (pos_q == last_pos);

  // frame word, index = send position; sync slot comes from sync_q
  always_comb begin
    frm_d = '0;
    for (int i = 0; i < B_W; i++) begin
      frm_d[i] = b1_i[B_W-1-i];
      if (rate_hi_i) frm_d[B_W+i] = b2_i[B_W-1-i];
    end
    if (rate_hi_i) begin
      frm_d[2*B_W]   = d_i[0];
      frm_d[2*B_W+1] = d_i[1];
      frm_d[2*B_W+2] = hk_i;
    end else begin
      frm_d[B_W] = d_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      frm_q  <= '0;
      sync_q <= 1'b1;
    end else if (bit_en_i) begin
      if (at_last) begin
        pos_q  <= '0;
        frm_q  <= frm_d;
        sync_q <= ~sync_q;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign bit_o = at_last ? sync_q : frm_q[pos_q];
  assign sof_o = (pos_q == '0);
endmodule

// File: rtl/lfc_rx_align.sv
module lfc_rx_align #(
  parameter int B_W         = 8,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_hi_i,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic take_o,
  output logic lock_o
);
  import lfc_pkg::*;

  localparam int HI_LEN = lfc_frame_len(B_W, 1'b1);
  localparam int LO_LEN = lfc_frame_len(B_W, 1'b0);
  localparam int PW     = $clog2(HI_LEN);
  localparam int GW     = $clog2(LOCK_FRAMES + 1);
  localparam int MW     = $clog2(LOSS_FRAMES + 1);

  lfc_sync_st_e  st_q, st_d;
  logic [PW-1:0] pos_q, last_pos;
  logic [GW-1:0] good_q, good_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          prev_q, prev_d, skip_q, skip_d, cand;

  assign last_pos = rate_hi_i ? PW'(HI_LEN - 1) : PW'(LO_LEN - 1);
  assign cand     = bit_en_i && !skip_q && (pos_q == last_pos);

  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    miss_d = miss_q;
    prev_d = prev_q;
    skip_d = skip_q;
    if (bit_en_i && skip_q) skip_d = 1'b0;
    if (cand) begin
      if (st_q == ST_HUNT) begin
        if (good_q == '0) begin
          good_d = GW'(1);
          prev_d = bit_i;
        end else if (bit_i != prev_q) begin
          prev_d = bit_i;
          if (good_q == GW'(LOCK_FRAMES - 1)) begin
            st_d   = ST_LOCK;
            good_d = '0;
            miss_d = '0;
          end else begin
            good_d = good_q + GW'(1);
          end
        end else begin
          good_d = '0;
          skip_d = 1'b1;
        end
      end else begin
        prev_d = ~prev_q;
        if (bit_i != prev_q) begin
          miss_d = '0;
        end else if (miss_q == MW'(LOSS_FRAMES - 1)) begin
          st_d   = ST_HUNT;
          miss_d = '0;
          good_d = '0;
          skip_d = 1'b1;
        end else begin
          miss_d = miss_q + MW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      pos_q  <= '0;
      good_q <= '0;
      miss_q <= '0;
      prev_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
      miss_q <= miss_d;
      prev_q <= prev_d;
      skip_q <= skip_d;
      // a skipped bit holds the position: candidate slides one bit later
      if (bit_en_i && !skip_q) begin
        if (pos_q == last_pos) pos_q <= '0;
        else                   pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign take_o = cand && (st_d == ST_LOCK);
  assign lock_o = (st_q == ST_LOCK);
endmodule

// File: rtl/lfc_rx_unpack.sv
module lfc_rx_unpack #(
  parameter int B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rate_hi_i,
  input  logic           bit_en_i,
  input  logic           bit_i,
  input  logic           take_i,
  output logic [B_W-1:0] b1_o,
  output logic [B_W-1:0] b2_o,
  output logic [1:0]     d_o,
  output logic           hk_o,
  output logic           upd_o
);
  localparam int HI_LEN = lfc_pkg::lfc_frame_len(B_W, 1'b1);
  localparam int LO_LEN = lfc_pkg::lfc_frame_len(B_W, 1'b0);
  localparam int SW     = HI_LEN - 1;

  logic [SW-1:0]  sh_q;
  logic [B_W-1:0] cb1, cb2;
  logic [1:0]     cd;
  logic           chk;

  // sh_q[0] is the bit just before the sync bit being taken
  always_comb begin
    for (int i = 0; i < B_W; i++) begin
      cb1[B_W-1-i] = rate_hi_i ? sh_q[HI_LEN-2-i] : sh_q[LO_LEN-2-i];
      cb2[B_W-1-i] = rate_hi_i & sh_q[HI_LEN-2-B_W-i];
    end
    cd  = rate_hi_i ? {sh_q[1], sh_q[2]} : {1'b0, sh_q[0]};
    chk = rate_hi_i & sh_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      b1_o  <= '0;
      b2_o  <= '0;
      d_o   <= '0;
      hk_o  <= 1'b0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= take_i;
      if (bit_en_i) sh_q <= {sh_q[SW-2:0], bit_i};
      if (take_i) begin
        b1_o <= cb1;
        b2_o <= cb2;
        d_o  <= cd;
        hk_o <= chk;
      end
    end
  end
endmodule

// File: rtl/lfc_line_framer.sv
module lfc_line_framer #(
  parameter int B_W         = 8,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rate_hi_i,
  input  logic           load_i,
  input  logic [B_W-1:0] b1_i,
  input  logic [B_W-1:0] b2_i,
  input  logic [1:0]     d_i,
  input  logic           hk_i,
  input  logic           tx_bit_en_i,
  output logic           tx_bit_o,
  output logic           tx_sof_o,
  input  logic           rx_bit_en_i,
  input  logic           rx_bit_i,
  output logic [B_W-1:0] rx_b1_o,
  output logic [B_W-1:0] rx_b2_o,
  output logic [1:0]     rx_d_o,
  output logic           rx_hk_o,
  output logic           rx_upd_o,
  output logic           rx_lock_o
);
  logic [B_W-1:0] h_b1, h_b2;
  logic [1:0]     h_d;
  logic           h_hk, take;

  lfc_tx_hold #(.B_W(B_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .b1_i(b1_i), .b2_i(b2_i), .d_i(d_i), .hk_i(hk_i),
    .b1_o(h_b1), .b2_o(h_b2), .d_o(h_d), .hk_o(h_hk)
  );

  lfc_tx_ser #(.B_W(B_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_hi_i(rate_hi_i), .bit_en_i(tx_bit_en_i),
    .b1_i(h_b1), .b2_i(h_b2), .d_i(h_d), .hk_i(h_hk),
    .bit_o(tx_bit_o), .sof_o(tx_sof_o)
  );

  lfc_rx_align #(.B_W(B_W), .LOCK_FRAMES(LOCK_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)) u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_hi_i(rate_hi_i), .bit_en_i(rx_bit_en_i),
    .bit_i(rx_bit_i), .take_o(take), .lock_o(rx_lock_o)
  );

  lfc_rx_unpack #(.B_W(B_W)) u_unpack (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_hi_i(rate_hi_i), .bit_en_i(rx_bit_en_i),
    .bit_i(rx_bit_i), .take_i(take),
    .b1_o(rx_b1_o), .b2_o(rx_b2_o), .d_o(rx_d_o), .hk_o(rx_hk_o), .upd_o(rx_upd_o)
  );
endmodule

// File: rtl/lfc_line_framer_chk.sv
module lfc_line_framer_chk #(
  parameter int B_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tx_bit_en_i,
  input logic           tx_sof_o,
  input logic           rx_bit_en_i,
  input logic           rx_upd_o,
  input logic           rx_lock_o,
  input logic [B_W-1:0] rx_b1_o,
  input logic [B_W-1:0] rx_b2_o,
  input logic [1:0]     rx_d_o,
  input logic           rx_hk_o
);
  // R3
  sof_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_bit_en_i && tx_sof_o) |=> !tx_sof_o);

  // R8
  upd_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_upd_o |-> rx_lock_o);

  // R8
  upd_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_upd_o |-> $past(rx_bit_en_i));

  // R8
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_upd_o |-> ($stable(rx_b1_o) && $stable(rx_b2_o) && $stable(rx_d_o) && $stable(rx_hk_o)));

  // R5
  lock_rise_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_lock_o) |-> rx_upd_o);

  // R6
  lock_moves_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_lock_o) |-> $past(rx_bit_en_i));
endmodule

bind lfc_line_framer lfc_line_framer_chk #(.B_W(B_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_bit_en_i(tx_bit_en_i), .tx_sof_o(tx_sof_o),
  .rx_bit_en_i(rx_bit_en_i), .rx_upd_o(rx_upd_o), .rx_lock_o(rx_lock_o),
  .rx_b1_o(rx_b1_o), .rx_b2_o(rx_b2_o), .rx_d_o(rx_d_o), .rx_hk_o(rx_hk_o)
);

// File: tb/sim_lfc_line_framer.sv
module sim_lfc_line_framer;
  logic       clk = 1'b0;
  logic       rst_n, rate_hi, load, hk, tx_en, rx_en, rx_bit;
  logic [7:0] b1, b2;
  logic [1:0] d;
  logic       tx_bit, tx_sof, rx_hk, rx_upd, rx_lock;
  logic [7:0] rx_b1, rx_b2;
  logic [1:0] rx_d;
  int         errs = 0, checks = 0;

  always #5 clk = ~clk;

  lfc_line_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .rate_hi_i(rate_hi), .load_i(load),
    .b1_i(b1), .b2_i(b2), .d_i(d), .hk_i(hk),
    .tx_bit_en_i(tx_en), .tx_bit_o(tx_bit), .tx_sof_o(tx_sof),
    .rx_bit_en_i(rx_en), .rx_bit_i(rx_bit),
    .rx_b1_o(rx_b1), .rx_b2_o(rx_b2), .rx_d_o(rx_d), .rx_hk_o(rx_hk),
    .rx_upd_o(rx_upd), .rx_lock_o(rx_lock)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_frame(input bit hi, input logic [7:0] fb1, input logic [7:0] fb2,
                                            input logic [1:0] fd, input bit fhk, input bit s);
    logic [19:0] w = '0;
    for (int i = 0; i < 8; i++) begin
      w[i] = fb1[7-i];
      if (hi) w[8+i] = fb2[7-i];
    end
    if (hi) begin
      w[16] = fd[0]; w[17] = fd[1]; w[18] = fhk; w[19] = s;
    end else begin
      w[8] = fd[0]; w[9] = s;
    end
    return w;
  endfunction

  task automatic do_reset(input bit hi);
    rate_hi = hi; rst_n = 1'b0; load = 0; tx_en = 0; rx_en = 0; rx_bit = 0;
    b1 = '0; b2 = '0; d = '0; hk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // grabs one frame; optional load at bit ld_at with given values
  task automatic tx_grab(input int len, input int ld_at, input logic [7:0] nb1, input logic [7:0] nb2,
                         input logic [1:0] nd, input bit nhk, output logic [19:0] w, output bit sof0);
    w = '0;
    for (int i = 0; i < len; i++) begin
      w[i] = tx_bit;
      if (i == 0) sof0 = tx_sof;
      tx_en = 1'b1;
      if (i == ld_at) begin
        load = 1'b1; b1 = nb1; b2 = nb2; d = nd; hk = nhk;
      end
      @(negedge clk);
      tx_en = 1'b0; load = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic rx_send(input bit hi, input logic [7:0] fb1, input logic [7:0] fb2,
                         input logic [1:0] fd, input bit fhk, input bit s);
    logic [19:0] w = exp_frame(hi, fb1, fb2, fd, fhk, s);
    int len = hi ? 20 : 10;
    for (int i = 0; i < len; i++) begin
      rx_bit = w[i]; rx_en = 1'b1;
      @(negedge clk);
      rx_en = 1'b0;
      if (i < len - 1) @(negedge clk);
    end
  endtask

  task automatic rx_raw(input bit v);
    rx_bit = v; rx_en = 1'b1;
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk(tx_sof == 1'b1, "R9 tx_sof", 32'(tx_sof), 1);
    chk(tx_bit == 1'b0, "R9 tx_bit", 32'(tx_bit), 0);
    chk(rx_lock == 1'b0, "R9 rx_lock", 32'(rx_lock), 0);
    chk(rx_upd == 1'b0, "R9 rx_upd", 32'(rx_upd), 0);
    chk({rx_b1, rx_b2, rx_d, rx_hk} == '0, "R9 fields", 32'({rx_b1, rx_b2, rx_d, rx_hk}), 0);
  endtask

  task automatic t_tx_hi;
    logic [19:0] w, e;
    bit s0;
    do_reset(1'b1);
    tx_grab(20, 0, 8'h3C, 8'hA1, 2'b10, 1'b1, w, s0);
    e = exp_frame(1, 8'h00, 8'h00, 2'b00, 0, 1);
    chk(w == e, "R4 frame0 unaffected by load", 32'(w), 32'(e));
    chk(s0 == 1'b1, "R3 sof at bit0", 32'(s0), 1);
    tx_grab(20, 5, 8'h5A, 8'h0F, 2'b01, 1'b0, w, s0);
    e = exp_frame(1, 8'h3C, 8'hA1, 2'b10, 1, 0);
    chk(w == e, "R1 hi frame order, R3 sync 0", 32'(w), 32'(e));
    tx_grab(20, -1, 8'h00, 8'h00, 2'b00, 1'b0, w, s0);
    e = exp_frame(1, 8'h5A, 8'h0F, 2'b01, 0, 1);
    chk(w == e, "R4 mid-frame load in next frame, R3 sync 1", 32'(w), 32'(e));
    chk(s0 == 1'b1, "R3 sof frame2", 32'(s0), 1);
  endtask

  task automatic t_tx_lo;
    logic [19:0] w, e;
    bit s0;
    do_reset(1'b0);
    tx_grab(10, 0, 8'hC5, 8'hFF, 2'b11, 1'b1, w, s0);
    e = exp_frame(0, 8'h00, 8'h00, 2'b00, 0, 1);
    chk(w == e, "R2 lo frame0", 32'(w), 32'(e));
    tx_grab(10, -1, 8'h00, 8'h00, 2'b00, 1'b0, w, s0);
    e = exp_frame(0, 8'hC5, 8'h00, 2'b01, 0, 0);
    chk(w == e, "R2 lo frame order", 32'(w), 32'(e));
    tx_grab(10, -1, 8'h00, 8'h00, 2'b00, 1'b0, w, s0);
    e = exp_frame(0, 8'hC5, 8'h00, 2'b01, 0, 1);
    chk(w == e, "R3 lo sync alternates", 32'(w), 32'(e));
  endtask

  task automatic t_rx_lock_loss;
    do_reset(1'b1);
    for (int k = 0; k < 7; k++)
      rx_send(1, 8'h10 + 8'(k), 8'hE0 - 8'(k), 2'(k), k[0], (k % 2) == 0);
    chk(rx_lock == 1'b0, "R5 no lock after 7 frames", 32'(rx_lock), 0);
    rx_send(1, 8'h17, 8'hD9, 2'b11, 1'b1, 1'b0);
    chk(rx_lock == 1'b1, "R5 lock on 8th frame", 32'(rx_lock), 1);
    chk(rx_upd == 1'b1, "R8 upd at lock", 32'(rx_upd), 1);
    chk({rx_b1, rx_b2, rx_d, rx_hk} == {8'h17, 8'hD9, 2'b11, 1'b1}, "R8 fields at lock",
        32'({rx_b1, rx_b2, rx_d, rx_hk}), 32'({8'h17, 8'hD9, 2'b11, 1'b1}));
    rx_send(1, 8'h66, 8'h99, 2'b01, 1'b0, 1'b1);
    chk({rx_b1, rx_b2, rx_d, rx_hk} == {8'h66, 8'h99, 2'b01, 1'b0}, "R8 fields follow",
        32'({rx_b1, rx_b2, rx_d, rx_hk}), 32'({8'h66, 8'h99, 2'b01, 1'b0}));
    rx_send(1, 8'h21, 8'h43, 2'b10, 1'b1, 1'b1);
    chk(rx_lock == 1'b1, "R6 lock kept after 1 miss", 32'(rx_lock), 1);
    rx_send(1, 8'h87, 8'h65, 2'b00, 1'b0, 1'b0);
    chk(rx_lock == 1'b1, "R6 lock kept after 2 misses", 32'(rx_lock), 1);
    rx_send(1, 8'hAA, 8'hBB, 2'b11, 1'b1, 1'b1);
    chk(rx_lock == 1'b0, "R6 lock dropped at 3rd miss", 32'(rx_lock), 0);
    chk(rx_upd == 1'b0, "R8 no upd on drop", 32'(rx_upd), 0);
    chk({rx_b1, rx_b2} == {8'h87, 8'h65}, "R8 fields held on drop",
        32'({rx_b1, rx_b2}), 32'({8'h87, 8'h65}));
    rx_send(1, 8'hF0, 8'h0F, 2'b11, 1'b1, 1'b0);
    chk({rx_b1, rx_b2} == {8'h87, 8'h65}, "R8 fields held while unlocked",
        32'({rx_b1, rx_b2}), 32'({8'h87, 8'h65}));
  endtask

  task automatic t_rx_slip;
    do_reset(1'b1);
    rx_raw(1'b0);
    for (int k = 0; k < 9; k++)
      rx_send(1, 8'h40 + 8'(k), 8'h0C, 2'b00, 1'b1, (k % 2) == 0);
    chk(rx_lock == 1'b0, "R7 not yet locked after slide", 32'(rx_lock), 0);
    rx_send(1, 8'h49, 8'h0C, 2'b00, 1'b1, 1'b0);
    chk(rx_lock == 1'b1, "R7 lock after one-bit slide", 32'(rx_lock), 1);
    chk(rx_b1 == 8'h49, "R7 aligned b1", 32'(rx_b1), 32'h49);
  endtask

  task automatic t_rx_lo;
    do_reset(1'b0);
    for (int k = 0; k < 8; k++)
      rx_send(0, 8'hC3 ^ 8'(k), 8'hFF, {1'b1, k[0]}, 1'b1, (k % 2) == 0);
    chk(rx_lock == 1'b1, "R5 lo lock on 8th frame", 32'(rx_lock), 1);
    chk(rx_b1 == 8'hC4, "R2 lo b1", 32'(rx_b1), 32'hC4);
    chk({rx_b2, rx_d, rx_hk} == {8'h00, 2'b01, 1'b0}, "R2 lo unused fields zero, d0",
        32'({rx_b2, rx_d, rx_hk}), 32'({8'h00, 2'b01, 1'b0}));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    t_reset();
    t_tx_hi();
    t_tx_lo();
    t_rx_lock_loss();
    t_rx_slip();
    t_rx_lo();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule